// File: doc/BRIEF.md
# Half-Word Masked GPIO Output Register Bank

This block keeps the 32-bit pad output-value register and the 32-bit pad output-enable register of a general-purpose I/O port. A bus master reaches it through a single register port with an address, a write enable, write data and read data. Each register can be written at full width. It can also be changed one half at a time through a masked-access address, so that any subset of bits can be set or cleared in a single write, with no read-modify-write.

A masked-access write carries two fields. Write bits 31:16 are a per-bit select mask and write bits 15:0 are the new values. Each masked address targets one half of one register. Only the bits whose mask bit is set take the new value, and every other bit of both registers keeps its value. The register flops drive the pad vectors directly, so an accepted write shows on the pads at the next clock edge.

Top module: `hwm_out_regs`

## Requirements
- R1: While `rstN` is low, both `padOut` and `padOe` are all zero.
- R2: A write to address 0 loads `wrData` into the output-value register, and it shows on `padOut` after the next rising clock edge.
- R3: A write to address 3 loads `wrData` into the output-enable register, and it shows on `padOe` after the next rising clock edge.
- R4: A write to address 1 treats `wrData[31:16]` as a mask and `wrData[15:0]` as values. Each `padOut[i]` with i in 0..15 whose mask bit i is 1 takes value bit i. All other bits of `padOut` are unchanged.
- R5: A write to address 2 uses the same mask and value fields on `padOut[31:16]`: mask bit i selects `padOut[16+i]`. `padOut[15:0]` is unchanged.
- R6: A write to address 4 behaves as R4, applied to `padOe[15:0]`.
- R7: A write to address 5 behaves as R5, applied to `padOe[31:16]`.
- R8: A write to any output-value address (0, 1, 2) leaves `padOe` unchanged. A write to any output-enable address (3, 4, 5) leaves `padOut` unchanged.
- R9: `rdData` is combinational. Address 0 returns the output-value register and address 3 returns the output-enable register.
- R10: Reading address 1, 2, 4 or 5 returns zero in bits 31:16. Bits 15:0 return the current contents of the half that the address targets.
- R11: Addresses 6 and 7 read as zero, and writes to them change neither register.
- R12: When `wrEn` is low, neither register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe for the current cycle |
| wrData | input | 32 | Write data: full word, or mask in 31:16 and values in 15:0 |
| rdData | output | 32 | Combinational read data for `addr` |
| padOut | output | 32 | Output-value vector to the pads |
| padOe | output | 32 | Output-enable vector to the pads |

## Verification
Every register write is due on `padOut` or `padOe` exactly one rising edge after the cycle that presents it. Read data is due in the same cycle as its address, because it is combinational. The bench drives each operation at a falling edge. Its reference model updates at the rising edge that follows, and the bench compares both pad vectors and `rdData` at the next falling edge, before it drives the next operation. Directed masked writes with empty, full and sparse masks are followed by a long mixed sequence that also includes unmapped addresses and idle cycles.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_OUT_FULL = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_OUT_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_OE_FULL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_OE_LO    = 3'd4;
  localparam logic [ADDR_W-1:0] A_OE_HI    = 3'd5;

  // write strobes for one register
  typedef struct packed {
    logic full;
    logic lower;
    logic upper;
  } halfStrobe_t;

  // control-to-datapath strobe bundle
  typedef struct packed {
    halfStrobe_t outWr;
    halfStrobe_t oeWr;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_OUT_FULL,
    RD_OUT_LO,
    RD_OUT_HI,
    RD_OE_FULL,
    RD_OE_LO,
    RD_OE_HI
  } rdSel_t;

endpackage

// File: rtl/hwm_ctrl.sv
module hwm_ctrl
  import hwm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output wrStrobe_t         strobe,
  output rdSel_t            rdSel
);

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    unique case (addr)
      A_OUT_FULL: begin strobe.outWr.full  = wrEn; rdSel = RD_OUT_FULL; end
      A_OUT_LO:   begin strobe.outWr.lower = wrEn; rdSel = RD_OUT_LO;   end
      A_OUT_HI:   begin strobe.outWr.upper = wrEn; rdSel = RD_OUT_HI;   end
      A_OE_FULL:  begin strobe.oeWr.full   = wrEn; rdSel = RD_OE_FULL;  end
      A_OE_LO:    begin strobe.oeWr.lower  = wrEn; rdSel = RD_OE_LO;    end
      A_OE_HI:    begin strobe.oeWr.upper  = wrEn; rdSel = RD_OE_HI;    end
      default:    begin strobe = '0; rdSel = RD_NONE; end
    endcase
  end

endmodule

// File: rtl/hwm_masked_reg.sv
module hwm_masked_reg
  import hwm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  halfStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] q
);

  localparam int HALF = WIDTH / 2;

  logic [HALF-1:0]  selMask;
  logic [HALF-1:0]  selVal;
  logic [WIDTH-1:0] nxt;

  assign selMask = wrData[WIDTH-1:HALF];
  assign selVal  = wrData[HALF-1:0];

  always_comb begin
    nxt = q;
    if (strobe.full) begin
      nxt = wrData;
    end else if (strobe.lower) begin
      nxt[HALF-1:0] = (selMask & selVal) | (~selMask & q[HALF-1:0]);
    end else if (strobe.upper) begin
      nxt[WIDTH-1:HALF] = (selMask & selVal) | (~selMask & q[WIDTH-1:HALF]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= nxt;
  end

endmodule

// File: rtl/hwm_datapath.sv
module hwm_datapath
  import hwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] outQ,
  output logic [DATA_W-1:0] oeQ
);

  localparam int HALF   = DATA_W / 2;
  localparam int NUM_RG = 2;

  halfStrobe_t       regStrobe [NUM_RG];
  logic [DATA_W-1:0] regQ      [NUM_RG];

  assign regStrobe[0] = strobe.outWr;
  assign regStrobe[1] = strobe.oeWr;

  for (genvar gi = 0; gi < NUM_RG; gi++) begin : gReg
    hwm_masked_reg #(.WIDTH(DATA_W)) uReg (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (regStrobe[gi]),
      .wrData (wrData),
      .q      (regQ[gi])
    );
  end

  assign outQ = regQ[0];
  assign oeQ  = regQ[1];

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_OUT_FULL: rdData = outQ;
      RD_OUT_LO:   rdData[HALF-1:0] = outQ[HALF-1:0];
      RD_OUT_HI:   rdData[HALF-1:0] = outQ[DATA_W-1:HALF];
      RD_OE_FULL:  rdData = oeQ;
      RD_OE_LO:    rdData[HALF-1:0] = oeQ[HALF-1:0];
      RD_OE_HI:    rdData[HALF-1:0] = oeQ[DATA_W-1:HALF];
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/hwm_out_regs.sv
module hwm_out_regs
  import hwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe
);

  wrStrobe_t strobe;
  rdSel_t    rdSel;

  hwm_ctrl uCtrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  hwm_datapath #(.DATA_W(DATA_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wrData (wrData),
    .rdData (rdData),
    .outQ   (padOut),
    .oeQ    (padOe)
  );

endmodule

// File: rtl/hwm_out_regs_chk.sv
module hwm_out_regs_chk
  import hwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic [31:0]       padOut,
  input logic [31:0]       padOe
);

  // R1: reset holds both vectors at zero
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (padOut == 32'h0 && padOe == 32'h0));

  // R2: direct value write lands next cycle
  a_r2_out_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OUT_FULL) |=> padOut == $past(wrData));

  // R4: lower masked write merges into low half
  a_r4_out_lo_merge: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OUT_LO) |=>
      padOut[15:0] == (($past(wrData[31:16]) & $past(wrData[15:0])) |
                       (~$past(wrData[31:16]) & $past(padOut[15:0]))));

  // R4: lower masked write keeps the high half
  a_r4_out_lo_keep_hi: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OUT_LO) |=> $stable(padOut[31:16]));

  // R7: upper masked enable write keeps the low half
  a_r7_oe_hi_keep_lo: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OE_HI) |=> $stable(padOe[15:0]));

  // R8: value writes never touch the enable register
  a_r8_out_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr <= A_OUT_HI) |=> $stable(padOe));

  // R10: masked reads return a zero mask field
  a_r10_masked_rd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_OUT_LO || addr == A_OUT_HI || addr == A_OE_LO || addr == A_OE_HI)
      |-> rdData[31:16] == 16'h0);

  // R12: idle cycles change nothing
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(padOut) && $stable(padOe)));

endmodule

bind hwm_out_regs hwm_out_regs_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .padOut (padOut),
  .padOe  (padOe)
);

// File: tb/sim_hwm_out_regs.sv
`timescale 1ns/1ps
module sim_hwm_out_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData, padOut, padOe;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] refOut = 32'h0;
  logic [31:0] refOe  = 32'h0;
  string lastTag = "R1";
  string otherTag = "R1";

  always #2 clk = ~clk;

  hwm_out_regs u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [31:0] mergeHalf(input logic [31:0] cur, input logic [31:0] w, input bit hi);
    logic [31:0] r = cur;
    for (int i = 0; i < 16; i++) begin
      if (w[16+i]) begin
        if (hi) r[16+i] = w[i];
        else    r[i]    = w[i];
      end
    end
    return r;
  endfunction

  // reference model: one behavioural update per rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refOut <= 32'h0;
      refOe  <= 32'h0;
    end else if (wrEn) begin
      case (addr)
        3'd0: refOut <= wrData;
        3'd1: refOut <= mergeHalf(refOut, wrData, 0);
        3'd2: refOut <= mergeHalf(refOut, wrData, 1);
        3'd3: refOe  <= wrData;
        3'd4: refOe  <= mergeHalf(refOe, wrData, 0);
        3'd5: refOe  <= mergeHalf(refOe, wrData, 1);
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return refOut;
      3'd1: return {16'h0, refOut[15:0]};
      3'd2: return {16'h0, refOut[31:16]};
      3'd3: return refOe;
      3'd4: return {16'h0, refOe[15:0]};
      3'd5: return {16'h0, refOe[31:16]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge: check the result of the previous op, then drive the next
  task automatic step(input logic [2:0] a, input logic we, input logic [31:0] d);
    @(negedge clk);
    cmp(lastTag,  "padOut", padOut, refOut);
    cmp(otherTag, "padOe",  padOe,  refOe);
    // R9 R10 R11: read data for the address currently applied
    cmp((addr == 3'd0 || addr == 3'd3) ? "R9" : (addr > 3'd5 ? "R11" : "R10"),
        "rdData", rdData, expRead(addr));
    addr = a; wrEn = we; wrData = d;
    if (!we) begin lastTag = "R12"; otherTag = "R12"; end
    else case (a)
      3'd0: begin lastTag = "R2"; otherTag = "R8"; end
      3'd1: begin lastTag = "R4"; otherTag = "R8"; end
      3'd2: begin lastTag = "R5"; otherTag = "R8"; end
      3'd3: begin lastTag = "R8"; otherTag = "R3"; end
      3'd4: begin lastTag = "R8"; otherTag = "R6"; end
      3'd5: begin lastTag = "R8"; otherTag = "R7"; end
      default: begin lastTag = "R11"; otherTag = "R11"; end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "padOut in reset", padOut, 32'h0);
    cmp("R1", "padOe in reset",  padOe,  32'h0);
    rstN = 1'b1;
    step(3'd0, 1, 32'hA5A5_3C3C);   // R2
    step(3'd1, 1, 32'h0000_FFFF);   // R4 empty mask
    step(3'd1, 1, 32'hFFFF_0000);   // R4 full mask clears low half
    step(3'd2, 1, 32'h8001_FFFF);   // R5 sparse mask
    step(3'd3, 1, 32'hFFFF_FFFF);   // R3
    step(3'd4, 1, 32'h00F0_0000);   // R6
    step(3'd5, 1, 32'hF000_0000);   // R7
    step(3'd6, 1, 32'hFFFF_FFFF);   // R11
    step(3'd7, 1, 32'h1234_5678);   // R11
    step(3'd0, 0, 32'h0);           // R12
    step(3'd4, 0, 32'hFFFF_FFFF);   // R12
    for (int n = 0; n < 3000; n++) begin
      step(3'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0), $urandom);
    end
    step(3'd2, 0, 32'h0);
    step(3'd5, 0, 32'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule